// File: doc/BRIEF.md
# Configurable SPI Master Controller

This block is a serial bus master that moves one word at a time between a core-side handshake and SPI peripherals. Software-style configuration inputs set the serial clock rate (a divider of the core clock), the clock idle level and sampling phase, the chip-select polarity, a single-device option with no chip select, and which of three chip-select lines a frame uses. A word is offered with `tx_valid` while `tx_ready` is high; `done` pulses when the frame has finished and `rx_data` holds the word captured from the bus.

Three wire modes are available. Standard mode is four-wire full duplex: the data out pin and the data in pin run at the same time. Bidirectional mode shares one data pin. Each frame either sends or receives, and the pin's driver is released for a receive frame. The command/data mode shifts 9-bit frames: one tag bit, then the byte. Displays use this tag to tell a command from a parameter.

All configuration inputs must stay stable while a frame is in flight.

Top module: `spi_master_ctl`

## Requirements
- R1: The SCLK half period H, in core clock cycles, is the divider with bit 0 cleared and then halved. When the even divider is zero (programmed 0 or 1), H is 32768, so the full period is 65536. During a frame every SCLK transition is H cycles after the previous one.
- R2: The selected chip select becomes active in the cycle after the word is accepted. The first SCLK transition comes H cycles later. The chip select goes inactive H cycles after the last transition, and `done` pulses for one cycle at that moment.
- R3: SCLK rests at `cfg_cpol` whenever no frame is active. A frame has exactly 16 transitions in 8-bit modes and 18 in the 9-bit mode.
- R4: Bits go MSB first. With `cfg_cpha`=0, the first bit is on the output from chip-select assertion, input is sampled on leading (away from idle) edges, and output changes on trailing edges. With `cfg_cpha`=1, output changes on leading edges and input is sampled on trailing edges.
- R5: Standard mode (`cfg_mode`=0, and also 3) is full duplex. `mosi` carries `tx_data`, and `rx_data` is the 8 bits sampled from `miso`.
- R6: The 9-bit mode (`cfg_mode`=2) shifts `tx_dc` first (1 marks data or a parameter, 0 marks a command), followed by the 8 data bits. `rx_data` is the last 8 bits sampled.
- R7: Bidirectional mode (`cfg_mode`=1) samples `sio_in` instead of `miso`. With `dir_recv`=1, `mosi_oe` is low for the whole frame. With only `dir_send`, or neither flag, `mosi_oe` stays high and the word is shifted out on `mosi`.
- R8: In bidirectional mode, a request with both `dir_send` and `dir_recv` set starts no frame. `err` pulses in the next cycle, `tx_ready` stays high, `done` stays low, and SCLK and the chip selects stay idle.
- R9: `cfg_cs_sel` 0, 1 and 2 activate `cs_o[0]`, `cs_o[1]` and `cs_o[2]`. Index 3, or `cfg_no_cs`=1, leaves every line inactive while SCLK still runs the frame.
- R10: With `cfg_cs_hi`=0, chip selects are active low and idle high. With `cfg_cs_hi`=1, they are active high and idle low.
- R11: `tx_ready` is high only when no frame is active. A `tx_valid` pulse during a frame starts nothing and does not change the word being shifted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_div | input | 16 | SCLK divider; bit 0 ignored, even zero means 65536 |
| cfg_mode | input | 2 | 0 standard, 1 bidirectional, 2 nine-bit command/data, 3 standard |
| cfg_cpol | input | 1 | SCLK idle level |
| cfg_cpha | input | 1 | 1 moves sampling to the trailing edge |
| cfg_cs_hi | input | 1 | Chip selects active high when 1 |
| cfg_no_cs | input | 1 | Keep all chip selects inactive |
| cfg_cs_sel | input | 2 | Chip-select index; 3 selects none |
| tx_valid | input | 1 | Word offered |
| tx_ready | output | 1 | Controller idle, a word can be accepted |
| tx_data | input | 8 | Word to send |
| tx_dc | input | 1 | Tag bit for the 9-bit mode (1 data, 0 command) |
| dir_send | input | 1 | Bidirectional mode: transmit frame |
| dir_recv | input | 1 | Bidirectional mode: receive frame |
| done | output | 1 | One-cycle pulse at frame end |
| err | output | 1 | One-cycle pulse on a rejected bidirectional request |
| rx_data | output | 8 | Word captured in the last frame |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Data out, or the shared pin's driven value |
| mosi_oe | output | 1 | Output enable for the shared pin |
| miso | input | 1 | Data in for standard and 9-bit modes |
| sio_in | input | 1 | Value read back from the shared pin |
| cs_o | output | 3 | Chip-select lines |

## Verification
The bench runs a bus-level peripheral model. It records the cycle of each SCLK transition, so it catches a wrong half period, and especially an odd divider that was not rounded down or a zero divider that was not widened to 65536. It also catches a chip select that opens or closes with no half-period margin. The model samples and launches bits on the edges each phase setting calls for. A design that swaps edges for one of the four polarity and phase pairs, or that shifts LSB first, returns a corrupted word. Further directed cases cover these faults:
- a 9-bit frame that drops or inverts the tag bit;
- a receive frame that keeps driving the shared pin;
- a doubled bidirectional request that still clocks a frame;
- a chip-select index 3 that wraps onto a real line;
- a word offered mid-frame that restarts or corrupts the frame in flight.

// File: rtl/spim_pkg.sv
package spim_pkg;

  typedef enum logic [1:0] {
    SPIM_STD   = 2'd0,
    SPIM_BIDIR = 2'd1,
    SPIM_CMD9  = 2'd2,
    SPIM_RSV   = 2'd3
  } spim_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_TAIL = 2'd2
  } spim_state_e;

endpackage

// File: rtl/spim_timer.sv
module spim_timer #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  localparam logic [DIV_W-1:0] HALF_MAX = DIV_W'(1) << (DIV_W - 1);
  localparam logic [DIV_W-1:0] EVEN_MSK = {{(DIV_W-1){1'b1}}, 1'b0};

  // Half SCLK period in core cycles: even divisor / 2, zero maps to the widest period.
  function automatic logic [DIV_W-1:0] half_len(input logic [DIV_W-1:0] d);
    logic [DIV_W-1:0] ev;
    ev = d & EVEN_MSK;
    if (ev == '0) return HALF_MAX;
    return ev >> 1;
  endfunction

  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] half;

  assign half = half_len(div);
  assign tick = run && (cnt == half - DIV_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!run || tick) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + DIV_W'(1);
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < half); // R1

endmodule

// File: rtl/spim_shifter.sv
module spim_shifter #(
  parameter int FW = 9,
  parameter int RW = 8,
  parameter int EW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [FW-1:0] frame,
  input  logic [EW-1:0] edges_tot,
  input  logic          edge_go,
  input  logic          cpha,
  input  logic          din,
  output logic          sout,
  output logic          last_edge,
  output logic          ph,
  output logic [RW-1:0] rword
);

  logic [FW-1:0] sreg;
  logic [EW-1:0] eidx;
  logic          is_sample;
  logic          is_launch;

  // Even edge index is a leading edge; cpha picks which kind samples.
  assign is_sample = (eidx[0] == cpha);
  assign is_launch = !is_sample && !(cpha && (eidx == '0));
  assign last_edge = (eidx == edges_tot - EW'(1));
  assign sout      = sreg[FW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg  <= '0;
      rword <= '0;
      eidx  <= '0;
      ph    <= 1'b0;
    end else if (load) begin
      sreg  <= frame;
      rword <= '0;
      eidx  <= '0;
      ph    <= 1'b0;
    end else if (edge_go) begin
      ph   <= ~ph;
      eidx <= eidx + EW'(1);
      if (is_sample) rword <= {rword[RW-2:0], din};
      if (is_launch) sreg  <= {sreg[FW-2:0], 1'b0};
    end
  end

  AST_PH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!edge_go && !load) |=> $stable(ph)); // R1

  AST_LAST_PH: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_go && last_edge) |-> ph); // R3

endmodule

// File: rtl/spim_csgen.sv
module spim_csgen #(
  parameter int NCS = 3,
  parameter int SW  = 2
) (
  input  logic           active,
  input  logic           no_cs,
  input  logic [SW-1:0]  sel,
  input  logic           act_hi,
  output logic [NCS-1:0] cs_o
);

  logic [NCS-1:0] hit;

  for (genvar k = 0; k < NCS; k++) begin : g_cs
    assign hit[k]  = active && !no_cs && (sel == SW'(k));
    assign cs_o[k] = act_hi ? hit[k] : !hit[k];
  end

endmodule

// File: rtl/spi_master_ctl.sv
module spi_master_ctl
  import spim_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int DATA_W = 8,
  parameter int NUM_CS = 3,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic [1:0]        cfg_mode,
  input  logic              cfg_cpol,
  input  logic              cfg_cpha,
  input  logic              cfg_cs_hi,
  input  logic              cfg_no_cs,
  input  logic [SEL_W-1:0]  cfg_cs_sel,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_dc,
  input  logic              dir_send,
  input  logic              dir_recv,
  output logic              done,
  output logic              err,
  output logic [DATA_W-1:0] rx_data,
  output logic              sclk,
  output logic              mosi,
  output logic              mosi_oe,
  input  logic              miso,
  input  logic              sio_in,
  output logic [NUM_CS-1:0] cs_o
);

  localparam int FRAME_W = DATA_W + 1;
  localparam int EDGE_W  = $clog2(2 * FRAME_W + 1);
  localparam logic [EDGE_W-1:0] EDGES_8 = EDGE_W'(2 * DATA_W);
  localparam logic [EDGE_W-1:0] EDGES_9 = EDGE_W'(2 * FRAME_W);

  spim_state_e state;
  spim_mode_e  cfg_m;
  spim_mode_e  mode_q;
  logic        rx_q;

  logic               busy;
  logic               bad_req;
  logic               accept;
  logic               tick;
  logic               edge_go;
  logic               last_edge;
  logic               ph;
  logic               sout;
  logic               din;
  logic [FRAME_W-1:0] frame;
  logic [EDGE_W-1:0]  edges_tot;
  logic [DATA_W-1:0]  rword;

  assign cfg_m     = spim_mode_e'(cfg_mode);
  assign busy      = (state != ST_IDLE);
  assign tx_ready  = !busy;
  assign bad_req   = (cfg_m == SPIM_BIDIR) && dir_send && dir_recv;
  assign accept    = tx_valid && !busy && !bad_req;
  assign frame     = (cfg_m == SPIM_CMD9) ? {tx_dc, tx_data} : {tx_data, 1'b0};
  assign edges_tot = (mode_q == SPIM_CMD9) ? EDGES_9 : EDGES_8;
  assign edge_go   = tick && (state == ST_RUN);
  assign din       = (mode_q == SPIM_BIDIR) ? sio_in : miso;
  assign sclk      = cfg_cpol ^ ph;
  assign mosi      = sout;
  assign mosi_oe   = !(busy && (mode_q == SPIM_BIDIR) && rx_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      mode_q  <= SPIM_STD;
      rx_q    <= 1'b0;
      done    <= 1'b0;
      err     <= 1'b0;
      rx_data <= '0;
    end else begin
      done <= 1'b0;
      err  <= !busy && tx_valid && bad_req;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            state  <= ST_RUN;
            mode_q <= cfg_m;
            rx_q   <= (cfg_m == SPIM_BIDIR) && dir_recv;
          end
        end
        ST_RUN: begin
          if (edge_go && last_edge) state <= ST_TAIL;
        end
        ST_TAIL: begin
          if (tick) begin
            state   <= ST_IDLE;
            done    <= 1'b1;
            rx_data <= rword;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  spim_timer #(.DIV_W(DIV_W)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (busy),
    .div  (cfg_div),
    .tick (tick)
  );

  spim_shifter #(.FW(FRAME_W), .RW(DATA_W), .EW(EDGE_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .frame    (frame),
    .edges_tot(edges_tot),
    .edge_go  (edge_go),
    .cpha     (cfg_cpha),
    .din      (din),
    .sout     (sout),
    .last_edge(last_edge),
    .ph       (ph),
    .rword    (rword)
  );

  spim_csgen #(.NCS(NUM_CS), .SW(SEL_W)) u_cs (
    .active(busy),
    .no_cs (cfg_no_cs),
    .sel   (cfg_cs_sel),
    .act_hi(cfg_cs_hi),
    .cs_o  (cs_o)
  );

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (tx_ready && !err)); // R2

  AST_SCLK_REST: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sclk == cfg_cpol)); // R3

  AST_OE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (mode_q != SPIM_BIDIR)) |-> mosi_oe); // R7

  AST_ERR_NO_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (tx_ready && !done)); // R8

  AST_NOCS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cfg_no_cs) |-> (cs_o == {NUM_CS{!cfg_cs_hi}})); // R9

  AST_CS_REST: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (cs_o == {NUM_CS{!cfg_cs_hi}})); // R10

  AST_TAKE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready && !bad_req) |=> !tx_ready); // R11

endmodule

// File: tb/tb_spi_master_ctl.sv
module tb_spi_master_ctl;

  localparam int WDOG = 190000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [15:0] cfg_div = 16'd4;
  logic [1:0] cfg_mode = 2'd0;
  logic       cfg_cpol = 1'b0;
  logic       cfg_cpha = 1'b0;
  logic       cfg_cs_hi = 1'b0;
  logic       cfg_no_cs = 1'b0;
  logic [1:0] cfg_cs_sel = 2'd0;
  logic       tx_valid = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic       tx_dc = 1'b0;
  logic       dir_send = 1'b0;
  logic       dir_recv = 1'b0;
  logic       tx_ready, done, err, sclk, mosi, mosi_oe;
  logic [7:0] rx_data;
  logic [2:0] cs_o;
  logic       miso, sio_in;

  always #5 clk = ~clk;

  spi_master_ctl dut (
    .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_mode(cfg_mode),
    .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha), .cfg_cs_hi(cfg_cs_hi),
    .cfg_no_cs(cfg_no_cs), .cfg_cs_sel(cfg_cs_sel), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .tx_dc(tx_dc),
    .dir_send(dir_send), .dir_recv(dir_recv), .done(done), .err(err),
    .rx_data(rx_data), .sclk(sclk), .mosi(mosi), .mosi_oe(mosi_oe),
    .miso(miso), .sio_in(sio_in), .cs_o(cs_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Peripheral model state, sampled away from the active edge.
  int       frames = 0, total_edges = 0, ecount = 0, n_done = 0;
  int       t_cs = 0, t_first = 0, t_last = 0, t_end = 0, bad_gap = 0;
  int       s_pos = 0;
  logic [8:0] m_rx = '0;
  logic [8:0] s_word = '0;
  logic       s_drv = 1'b0;
  logic [2:0] cs_mid = '0;
  bit         oe_lo_seen = 0, oe_hi_seen = 0;
  logic       prev_rdy = 1'b1, prev_sclk = 1'b0;

  assign miso   = s_drv;
  assign sio_in = mosi_oe ? mosi : s_drv;

  function automatic int bench_half(input int div);
    int e;
    e = div - (div % 2);
    if (e == 0) return 32768;
    return e / 2;
  endfunction

  function automatic int nbits();
    return (cfg_mode == 2'd2) ? 9 : 8;
  endfunction

  always @(negedge clk) begin
    if (done) n_done++;
    if (!tx_ready && prev_rdy) begin
      frames++;
      ecount = 0; bad_gap = 0; t_cs = cyc; m_rx = '0; cs_mid = cs_o;
      oe_lo_seen = 0; oe_hi_seen = 0;
      s_pos = nbits() - 1;
      if (!cfg_cpha) begin
        s_drv = s_word[s_pos];
        s_pos--;
      end
    end
    if (!tx_ready) begin
      if (mosi_oe) oe_hi_seen = 1; else oe_lo_seen = 1;
    end
    if (sclk !== prev_sclk) begin
      total_edges++;
      if (!tx_ready) begin
        if (ecount == 0) t_first = cyc;
        else if (cyc - t_last != bench_half(int'(cfg_div))) bad_gap++;
        t_last = cyc;
        ecount++;
        if ((sclk != cfg_cpol) == !cfg_cpha) begin
          m_rx = {m_rx[7:0], mosi};
        end else if (s_pos >= 0) begin
          s_drv = s_word[s_pos];
          s_pos--;
        end
      end
    end
    if (tx_ready && !prev_rdy) t_end = cyc;
    prev_rdy  = tx_ready;
    prev_sclk = sclk;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_frame(input logic [7:0] d, input logic dc);
    int guard;
    @(negedge clk);
    tx_data = d; tx_dc = dc; tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    guard = 0;
    while (!done && guard < 100000) begin
      @(negedge clk);
      guard++;
    end
    @(negedge clk);
  endtask

  task automatic t_reset_state();
    check(tx_ready == 1'b1, "R11 ready after reset", tx_ready, 1);
    check(done == 1'b0 && err == 1'b0, "R2 no pulses after reset", {done, err}, 0);
    check(sclk == cfg_cpol, "R3 sclk idle after reset", sclk, cfg_cpol);
    check(cs_o == 3'b111, "R10 cs idle high after reset", cs_o, 7);
    check(mosi_oe == 1'b1, "R7 oe after reset", mosi_oe, 1);
  endtask

  task automatic t_std(input logic pol, input logic pha, input int div,
                       input logic [7:0] d, input logic [7:0] sw);
    int h;
    cfg_mode = 2'd0; cfg_cpol = pol; cfg_cpha = pha; cfg_div = 16'(div);
    s_word = {1'b0, sw};
    h = bench_half(div);
    repeat (2) @(negedge clk);
    do_frame(d, 1'b0);
    check(ecount == 16, "R3 edge count", ecount, 16);
    check(bad_gap == 0, "R1 half period", bad_gap, 0);
    check(t_first - t_cs == h, "R2 lead time", t_first - t_cs, h);
    check(t_end - t_last == h, "R2 trail time", t_end - t_last, h);
    check(m_rx[7:0] == d, "R4 bits seen on mosi", m_rx[7:0], d);
    check(rx_data == sw, "R5 word from miso", rx_data, sw);
    check(sclk == pol, "R3 sclk back at idle", sclk, pol);
  endtask

  task automatic t_cmd9(input logic dc, input logic [7:0] d);
    cfg_mode = 2'd2; cfg_cpol = 1'b0; cfg_cpha = 1'b0; cfg_div = 16'd2;
    s_word = 9'h1AB;
    do_frame(d, dc);
    check(ecount == 18, "R3 nine-bit edge count", ecount, 18);
    check(m_rx == {dc, d}, "R6 tag then byte", m_rx, {dc, d});
    check(rx_data == 8'hAB, "R6 received low byte", rx_data, 8'hAB);
  endtask

  task automatic t_bidir_tx();
    cfg_mode = 2'd1; cfg_cpol = 1'b0; cfg_cpha = 1'b1; cfg_div = 16'd4;
    dir_send = 1'b1; dir_recv = 1'b0; s_word = 9'h0FF;
    do_frame(8'hC6, 1'b0);
    check(m_rx[7:0] == 8'hC6, "R7 transmit on shared pin", m_rx[7:0], 8'hC6);
    check(oe_lo_seen == 0, "R7 driver kept on for transmit", oe_lo_seen, 0);
  endtask

  task automatic t_bidir_rx();
    cfg_mode = 2'd1; cfg_cpol = 1'b1; cfg_cpha = 1'b0; cfg_div = 16'd4;
    dir_send = 1'b0; dir_recv = 1'b1; s_word = 9'h096;
    do_frame(8'hFF, 1'b0);
    check(rx_data == 8'h96, "R7 receive from shared pin", rx_data, 8'h96);
    check(oe_hi_seen == 0, "R7 driver released for receive", oe_hi_seen, 0);
    check(mosi_oe == 1'b1, "R7 driver back after receive", mosi_oe, 1);
    dir_recv = 1'b0;
  endtask

  task automatic t_bidir_err();
    int f0, e0, d0;
    cfg_mode = 2'd1; dir_send = 1'b1; dir_recv = 1'b1;
    f0 = frames; e0 = total_edges; d0 = n_done;
    @(negedge clk);
    tx_data = 8'h55; tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    check(err == 1'b1, "R8 err pulse", err, 1);
    check(tx_ready == 1'b1, "R8 stays ready", tx_ready, 1);
    @(negedge clk);
    check(err == 1'b0, "R8 err one cycle", err, 0);
    repeat (20) @(negedge clk);
    check(frames == f0 && total_edges == e0, "R8 no frame clocked",
          total_edges - e0, 0);
    check(n_done == d0, "R8 no done", n_done - d0, 0);
    check(cs_o == 3'b111, "R8 cs idle", cs_o, 7);
    dir_send = 1'b0; dir_recv = 1'b0; cfg_mode = 2'd0;
  endtask

  task automatic t_cs_sel();
    logic [2:0] exp;
    cfg_mode = 2'd0; cfg_cpol = 1'b0; cfg_cpha = 1'b0; cfg_div = 16'd2;
    for (int s = 0; s < 4; s++) begin
      cfg_cs_sel = 2'(s);
      do_frame(8'h3A, 1'b0);
      exp = (s < 3) ? ~(3'b001 << s) : 3'b111;
      check(cs_mid == exp, "R9 line chosen by index", cs_mid, exp);
    end
    cfg_cs_sel = 2'd0; cfg_no_cs = 1'b1;
    do_frame(8'h3A, 1'b0);
    check(cs_mid == 3'b111, "R9 no chip select", cs_mid, 7);
    check(ecount == 16, "R9 sclk runs without chip select", ecount, 16);
    cfg_no_cs = 1'b0; cfg_cs_hi = 1'b1; cfg_cs_sel = 2'd2;
    @(negedge clk);
    check(cs_o == 3'b000, "R10 active-high idle level", cs_o, 0);
    do_frame(8'h3A, 1'b0);
    check(cs_mid == 3'b100, "R10 active-high assert", cs_mid, 4);
    cfg_cs_hi = 1'b0; cfg_cs_sel = 2'd0;
  endtask

  task automatic t_busy_ignore();
    int f0, guard;
    cfg_mode = 2'd0; cfg_cpol = 1'b0; cfg_cpha = 1'b0; cfg_div = 16'd4;
    s_word = 9'h011;
    f0 = frames;
    @(negedge clk);
    tx_data = 8'h33; tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    repeat (10) @(negedge clk);
    check(tx_ready == 1'b0, "R11 not ready mid-frame", tx_ready, 0);
    tx_data = 8'hCC; tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    guard = 0;
    while (!done && guard < 1000) begin
      @(negedge clk);
      guard++;
    end
    repeat (30) @(negedge clk);
    check(frames == f0 + 1, "R11 offer ignored while busy", frames - f0, 1);
    check(m_rx[7:0] == 8'h33, "R11 word in flight kept", m_rx[7:0], 8'h33);
  endtask

  task automatic t_div_wide(input int div);
    int e0, guard;
    cfg_mode = 2'd0; cfg_div = 16'(div);
    e0 = total_edges;
    @(negedge clk);
    tx_data = 8'h80; tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    guard = 0;
    while (total_edges == e0 && guard < 40000) begin
      @(negedge clk);
      guard++;
    end
    @(negedge clk);
    check(t_first - t_cs == 32768, "R1 zero divisor means 65536",
          t_first - t_cs, 32768);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cfg_div = 16'd4;
  endtask

  initial begin
    bit wd_hit;
    wd_hit = 0;
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_std(1'b0, 1'b0, 4, 8'hA5, 8'h3C);
        t_std(1'b0, 1'b1, 2, 8'h5A, 8'hC3);
        t_std(1'b1, 1'b0, 6, 8'h81, 8'h7E);
        t_std(1'b1, 1'b1, 7, 8'h0F, 8'hF0);
        t_cmd9(1'b0, 8'h2C);
        t_cmd9(1'b1, 8'hD3);
        t_bidir_tx();
        t_bidir_rx();
        t_bidir_err();
        t_cs_sel();
        t_busy_ignore();
        t_div_wide(0);
        t_div_wide(1);
      end
      begin
        repeat (WDOG) @(posedge clk);
        wd_hit = 1;
      end
    join_any
    disable fork;
    if (wd_hit) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected below %0d", cyc, WDOG);
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule